// File: doc/BRIEF.md
# Pipelined Parallel Matrix Multiplier

This block multiplies two square signed integer matrices, C = A x B, of dimension `DIM` (a power of two, default 16). Software or a loader first writes A and B into local storage through one shared load port. A start pulse then launches a run. The run walks every (row, column) pair of C in row-major order as one flattened index stream and issues one pair per clock.

For each pair the block reads a whole row of A and a whole column of B in a single cycle. Both operands have `DIM` elements. A is banked by its column index and B is banked by its row index, so element k of both operands always comes from bank k. All `DIM` products are formed in parallel, then summed in a wide accumulator that cannot overflow. Each result leaves on an output stream together with a valid flag and its row and column indices. A one-cycle done pulse marks the end of the run.

Top module: `mat_mul`

## Requirements
- R1: After reset, `c_valid` and `done` are low and stay low until a run is started.
- R2: While no run is in progress, a write with `ld_en` high stores `ld_data` into A when `ld_sel` is 0 and into B when `ld_sel` is 1. The address `ld_addr` is row-major, so element (r, c) is at address r*DIM + c.
- R3: Each output equals the sum over k of A(row,k) * B(k,col). Elements are two's-complement signed values of `DW` bits. The sum is returned exactly in 2*DW + log2(DIM) bits, with no overflow even for the most negative inputs.
- R4: A run produces exactly DIM*DIM outputs on consecutive cycles with no gaps. The outputs come in row-major order, starting at (0,0), and `c_row`/`c_col` carry the indices of each element.
- R5: If `start` is sampled high at a rising edge while idle, the first output is valid after the third rising edge that follows.
- R6: `done` is high for exactly one cycle, and that cycle is the one after the output for (DIM-1, DIM-1).
- R7: `start` has no effect while a run is in progress.
- R8: Load writes have no effect on either matrix while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load write enable |
| ld_sel | input | 1 | Load target: 0 = A, 1 = B |
| ld_addr | input | 2*log2(DIM) | Row-major element address |
| ld_data | input | DW | Signed element value |
| start | input | 1 | Start a run (taken only while idle) |
| c_valid | output | 1 | Output element valid |
| c_row | output | log2(DIM) | Row index of the output element |
| c_col | output | log2(DIM) | Column index of the output element |
| c_data | output | 2*DW+log2(DIM) | Signed result element |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
Random signed matrices exercise general sums and catch bank or index mix-ups, because such a mix-up moves a product to the wrong position. An identity B must give back A unchanged, which separates row/column swaps from arithmetic faults. All-most-negative and mixed-extreme matrices push the sum to its widest magnitude and expose a truncated or zero-extended accumulator. A run with stray start pulses and load writes injected mid-stream shows up as broken ordering or changed results if either is wrongly honoured.

// File: rtl/mat_mul.sv
module mat_mul #(
  parameter int DIM = 16,
  parameter int DW  = 8,
  localparam int IW = $clog2(DIM),
  localparam int PW = 2 * DW,
  localparam int AW = PW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [2*IW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  output logic          c_valid,
  output logic [IW-1:0] c_row,
  output logic [IW-1:0] c_col,
  output logic [AW-1:0] c_data,
  output logic          done
);
  localparam logic [2*IW-1:0] LAST = {(2*IW){1'b1}};

  logic signed [DW-1:0] a_mem [DIM][DIM];
  logic signed [DW-1:0] b_mem [DIM][DIM];
  logic signed [DW-1:0] a_row [DIM];
  logic signed [DW-1:0] b_col [DIM];
  logic signed [PW-1:0] prod  [DIM];

  logic            running;
  logic [2*IW-1:0] cnt;
  logic            v1, v2;
  logic [IW-1:0]   i1, j1, i2, j2;
  logic [AW-1:0]   sum_c;

  wire [IW-1:0] ld_hi  = ld_addr[2*IW-1:IW];
  wire [IW-1:0] ld_lo  = ld_addr[IW-1:0];
  wire [IW-1:0] cnt_i  = cnt[2*IW-1:IW];
  wire [IW-1:0] cnt_j  = cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (ld_en && !running) begin
      if (!ld_sel) a_mem[ld_lo][ld_hi] <= ld_data;
      else         b_mem[ld_hi][ld_lo] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= start;
      cnt     <= '0;
    end else begin
      running <= (cnt != LAST);
      cnt     <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    i1 <= cnt_i;
    j1 <= cnt_j;
    i2 <= i1;
    j2 <= j1;
    for (int k = 0; k < DIM; k++) begin
      a_row[k] <= a_mem[k][cnt_i];
      b_col[k] <= b_mem[k][cnt_j];
      prod[k]  <= a_row[k] * b_col[k];
    end
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < DIM; k++)
      sum_c = sum_c + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      c_valid <= 1'b0;
      done    <= 1'b0;
    end else begin
      v1      <= running;
      v2      <= v1;
      c_valid <= v2;
      done    <= c_valid && ({c_row, c_col} == LAST);
    end
  end

  always_ff @(posedge clk) begin
    c_row  <= i2;
    c_col  <= j2;
    c_data <= sum_c;
  end
endmodule

// File: rtl/mat_mul_chk.sv
module mat_mul_chk #(
  parameter int DIM = 16,
  parameter int DW  = 8,
  localparam int IW = $clog2(DIM),
  localparam int AW = 2 * DW + IW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          c_valid,
  input logic [IW-1:0] c_row,
  input logic [IW-1:0] c_col,
  input logic [AW-1:0] c_data,
  input logic          done
);
  localparam logic [IW-1:0] MAXI = {IW{1'b1}};

  p_first_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> (c_row == '0 && c_col == '0));

  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_col != MAXI) |=>
      (c_valid && c_col == IW'($past(c_col) + 1'b1) && c_row == $past(c_row)));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_col == MAXI && c_row != MAXI) |=>
      (c_valid && c_col == '0 && c_row == IW'($past(c_row) + 1'b1)));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(c_valid && c_row == MAXI && c_col == MAXI));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_data_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> !$isunknown(c_data));
endmodule

bind mat_mul mat_mul_chk #(.DIM(DIM), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_row(c_row),
  .c_col(c_col), .c_data(c_data), .done(done)
);

// File: tb/mat_mul_tb.sv
module mat_mul_tb;
  localparam int DIM = 16;
  localparam int DW  = 8;
  localparam int IW  = $clog2(DIM);
  localparam int AW  = 2 * DW + IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [2*IW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic c_valid, done;
  logic [IW-1:0] c_row, c_col;
  logic [AW-1:0] c_data;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int ea [DIM][DIM];
  int eb [DIM][DIM];

  always #4 clk = ~clk;

  mat_mul #(.DIM(DIM), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
    .c_valid(c_valid), .c_row(c_row), .c_col(c_col),
    .c_data(c_data), .done(done)
  );

  function automatic longint exp_c(int r, int c);
    longint s = 0;
    for (int k = 0; k < DIM; k++) s += longint'(ea[r][k]) * longint'(eb[k][c]);
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(bit sel, int r, int c, int v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = (2*IW)'(r * DIM + c); ld_data = DW'(v);
    @(negedge clk);
    ld_en = 1'b0;
    if (sel) eb[r][c] = v; else ea[r][c] = v;
  endtask

  task automatic load_all(int mode_a, int mode_b);
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        int va, vb;
        va = (mode_a == 0) ? $signed(DW'($urandom)) : mode_a;
        vb = (mode_b == 0) ? $signed(DW'($urandom)) :
             (mode_b == 1) ? ((r == c) ? 1 : 0) : mode_b;
        load(1'b0, r, c, va);
        load(1'b1, r, c, vb);
      end
  endtask

  task automatic run(bit noise);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 1; cyc <= DIM*DIM + 6; cyc++) begin
      int e;
      @(negedge clk);
      e = cyc - 3;
      check((cyc == 3) ? "R5" : "R4", longint'(c_valid),
            longint'(e >= 0 && e < DIM*DIM));
      if (e >= 0 && e < DIM*DIM && c_valid) begin
        check("R4", longint'({c_row, c_col}), longint'(e));
        check("R3", longint'($signed(c_data)), exp_c(e / DIM, e % DIM));
      end
      check("R6", longint'(done), longint'(cyc == DIM*DIM + 3));
      if (noise && cyc >= 5 && cyc < 40) begin
        // R7 and R8: stray start and writes mid-run must be ignored
        start = cyc[0];
        ld_en = 1'b1; ld_sel = cyc[1];
        ld_addr = (2*IW)'($urandom); ld_data = DW'($urandom);
      end else begin
        start = 1'b0; ld_en = 1'b0;
      end
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", longint'(c_valid), 0);
    check("R1", longint'(done), 0);
    load_all(0, 0);
    check("R1", longint'(c_valid), 0);
    run(1'b0);                 // R2 R3 random
    load_all(0, 1);
    run(1'b0);                 // identity B
    load_all(-128, -128);
    run(1'b0);                 // largest positive sum
    load_all(127, -128);
    run(1'b0);                 // largest negative sum
    load_all(0, 0);
    run(1'b1);                 // R7 R8 noise
    run(1'b0);                 // R8 matrices unchanged afterwards
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule